// File: doc/BRIEF.md
# Inline-Tag Variable-Block Set Lookup

This block decides whether one cache set can satisfy a read of a run of words from a single 64-byte region, in a cache that keeps no separate tag array. The whole set arrives as 32 words of 64 bits, together with a 32-bit marker map whose set bits say which words hold a tag entry rather than data. Each tag entry describes one partial block: a contiguous run of words inside one region, stored in the set words that directly follow the tag word. Blocks may be of any length from one to eight words, and a set may hold any number of them.

For a request the block finds every marked word and decodes it. It keeps the entries whose region tag matches and that are well formed. It then works out, lane by lane, which requested region words those entries cover. It reports a hit, a partial miss or a full miss, a mask of covered requested words, and the eight data lanes gathered from one or more blocks. Uncovered lanes read as zero. The request is taken through a valid/ready handshake and the answer comes back from one register stage.

Top module: `itl_set_lookup`

## Requirements
- R1: Only set words whose bit in `tag_map` is 1 are treated as tag entries; a word with a tag-like bit pattern but a 0 marker bit contributes nothing.
- R2: A tag word holds the start word offset in bits [2:0], the end word offset in bits [5:3] and an entry-valid flag in bit 6. An entry with bit 6 at 0, or with end below start, is ignored.
- R3: Region word `l` served by a block whose tag sits at set position `p` with start offset `s` is read from set word `p+1+(l-s)`.
- R4: An entry whose data words would extend beyond set word 31 (that is, `p+1+(end-start) > 31`) is ignored.
- R5: An entry matches only when its bits [63:7] equal `req_tag`.
- R6: A request whose words `req_lo..req_hi` are all covered by matching entries is a hit, even when the words come from several blocks.
- R7: A request with some but not all requested words covered is a partial miss.
- R8: A request with no requested word covered is a full miss; a request with `req_hi < req_lo` has no requested words and is always a full miss with a zero mask.
- R9: `rsp_mask` bit `l` is 1 exactly when word `l` is requested and covered; data lane `l` (bits `64*l+63 : 64*l` of `rsp_data`) is zero whenever that mask bit is 0.
- R10: When two matching entries both cover a word, the entry whose tag word has the lower set position supplies it.
- R11: Every response carries exactly one of hit, partial miss and full miss.
- R12: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) is answered with `rsp_valid` 1 right after that edge; `req_ready` is 1 when `rsp_valid` is 0 or `rsp_ready` is 1, and a response not taken stays unchanged.
- R13: While `rst_n` is 0 at a clock edge, `rsp_valid` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| set_data | input | 2048 | The 32 set words, word `i` in bits `64*i+63 : 64*i` |
| tag_map | input | 32 | Bit `i` marks set word `i` as a tag entry |
| req_tag | input | 57 | Region tag of the request |
| req_lo | input | 3 | First requested region word |
| req_hi | input | 3 | Last requested region word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_hit | output | 1 | All requested words covered |
| rsp_partial | output | 1 | Some, not all, requested words covered |
| rsp_miss | output | 1 | No requested word covered |
| rsp_mask | output | 8 | Covered requested words |
| rsp_data | output | 512 | Eight gathered data lanes, lane `l` in bits `64*l+63 : 64*l` |

## Verification
The hardest situation to reach is a word covered twice, by two matching blocks with different data placement, where a wrong priority or wrong offset arithmetic still returns some plausible set word. The bench builds a set by hand with overlapping blocks at chosen positions, so that every candidate source word carries a distinct value naming its set position, and the lane value then shows exactly which block and which offset were used. Entries that must be ignored (unmarked, invalid, reversed, running past the set end) are placed so that they would cover the requested words if they were wrongly accepted.

// File: rtl/itl_pkg.sv
// Package itl_pkg
// Shared constants for the inline-tag set lookup: word width, region size and
// the bit layout of a tag word. Assumes a region of a power-of-two word count.
package itl_pkg;
    localparam int WORD_W       = 64;
    localparam int REGION_WORDS = 8;
    localparam int OFF_W        = $clog2(REGION_WORDS);
    localparam int START_LSB    = 0;
    localparam int END_LSB      = OFF_W;
    localparam int VLD_BIT      = 2 * OFF_W;
    localparam int RTAG_LSB     = 2 * OFF_W + 1;
    localparam int RTAG_W       = WORD_W - RTAG_LSB;

    // Lanes lo..hi set; an empty mask when hi < lo.
    function automatic logic [REGION_WORDS-1:0] range_mask(
        input logic [OFF_W-1:0] lo,
        input logic [OFF_W-1:0] hi
    );
        logic [REGION_WORDS-1:0] m;
        for (int l = 0; l < REGION_WORDS; l++) begin
            m[l] = (OFF_W'(l) >= lo) && (OFF_W'(l) <= hi);
        end
        return m;
    endfunction
endpackage

// File: rtl/itl_entry_decode.sv
// Module itl_entry_decode
// Decodes every set position as a possible tag entry and reports, per position,
// which region words that entry covers for the requested region tag. A position
// covers nothing unless it is marked, valid, well ordered, tag-matching, and its
// data fits inside the set. Purely combinational.
module itl_entry_decode
    import itl_pkg::*;
#(
    parameter int SET_WORDS = 32
) (
    input  logic [SET_WORDS*WORD_W-1:0]               set_data,
    input  logic [SET_WORDS-1:0]                      tag_map,
    input  logic [RTAG_W-1:0]                         req_tag,
    output logic [SET_WORDS-1:0][REGION_WORDS-1:0]    cov_map,
    output logic [SET_WORDS-1:0][OFF_W-1:0]           start_off
);
    localparam int IDX_W = $clog2(SET_WORDS);

    for (genvar p = 0; p < SET_WORDS; p++) begin : g_pos
        logic [WORD_W-1:0] word;
        logic [OFF_W-1:0]  s_off;
        logic [OFF_W-1:0]  e_off;
        logic [IDX_W:0]    last_idx;
        logic              fits;
        logic              match;

        // Split the word into tag-entry fields.
        always_comb begin
            word     = set_data[p*WORD_W +: WORD_W];
            s_off    = word[START_LSB +: OFF_W];
            e_off    = word[END_LSB +: OFF_W];
            last_idx = (IDX_W+1)'(p + 1) + (IDX_W+1)'(e_off - s_off);
            fits     = last_idx <= (IDX_W+1)'(SET_WORDS - 1);
        end

        // Decide whether this position is a usable matching entry.
        always_comb begin
            match = tag_map[p] && word[VLD_BIT] && (e_off >= s_off) && fits
                    && (word[RTAG_LSB +: RTAG_W] == req_tag);
        end

        // Mark the region words the entry holds.
        always_comb begin
            for (int l = 0; l < REGION_WORDS; l++) begin
                cov_map[p][l] = match && (OFF_W'(l) >= s_off) && (OFF_W'(l) <= e_off);
            end
            start_off[p] = s_off;
        end
    end
endmodule

// File: rtl/itl_lane_gather.sv
// Module itl_lane_gather
// For each region word lane, picks the lowest-positioned covering entry and
// reads the matching data word from the set. Lanes that are not requested or
// not covered output zero. Assumes cov_map only flags entries whose data fits.
module itl_lane_gather
    import itl_pkg::*;
#(
    parameter int SET_WORDS = 32
) (
    input  logic [SET_WORDS*WORD_W-1:0]               set_data,
    input  logic [SET_WORDS-1:0][REGION_WORDS-1:0]    cov_map,
    input  logic [SET_WORDS-1:0][OFF_W-1:0]           start_off,
    input  logic [REGION_WORDS-1:0]                   req_mask,
    output logic [REGION_WORDS-1:0]                   lane_cov,
    output logic [REGION_WORDS*WORD_W-1:0]            lane_data
);
    localparam int IDX_W = $clog2(SET_WORDS);

    for (genvar l = 0; l < REGION_WORDS; l++) begin : g_lane
        logic             found;
        logic [IDX_W-1:0] sel_pos;
        logic [IDX_W-1:0] rd_idx;

        // Priority pick: scanning downward leaves the lowest covering position.
        always_comb begin
            found   = 1'b0;
            sel_pos = '0;
            for (int q = SET_WORDS - 1; q >= 0; q--) begin
                if (cov_map[q][l]) begin
                    found   = 1'b1;
                    sel_pos = IDX_W'(q);
                end
            end
        end

        // Read the lane's word at tag position + 1 + (lane - start).
        always_comb begin
            rd_idx = sel_pos + IDX_W'(1) + IDX_W'(l) - IDX_W'(start_off[sel_pos]);
            lane_cov[l] = found && req_mask[l];
            lane_data[l*WORD_W +: WORD_W] = lane_cov[l]
                ? set_data[int'(rd_idx)*WORD_W +: WORD_W] : '0;
        end
    end
endmodule

// File: rtl/itl_set_lookup.sv
// Module itl_set_lookup (top)
// Hit detection and data gather for one set with tags stored inline with data.
// A request is taken on valid/ready, evaluated combinationally, and its result
// is held in one register stage until the response side takes it.
// Assumes set_data and tag_map are stable while req_valid is high.
module itl_set_lookup
    import itl_pkg::*;
#(
    parameter int SET_WORDS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SET_WORDS*WORD_W-1:0]   set_data,
    input  logic [SET_WORDS-1:0]          tag_map,
    input  logic [RTAG_W-1:0]             req_tag,
    input  logic [OFF_W-1:0]              req_lo,
    input  logic [OFF_W-1:0]              req_hi,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic                          rsp_hit,
    output logic                          rsp_partial,
    output logic                          rsp_miss,
    output logic [REGION_WORDS-1:0]       rsp_mask,
    output logic [REGION_WORDS*WORD_W-1:0] rsp_data
);
    logic [SET_WORDS-1:0][REGION_WORDS-1:0] cov_map;
    logic [SET_WORDS-1:0][OFF_W-1:0]        start_off;
    logic [REGION_WORDS-1:0]                req_mask;
    logic [REGION_WORDS-1:0]                lane_cov;
    logic [REGION_WORDS*WORD_W-1:0]         lane_data;
    logic                                   c_hit;
    logic                                   c_partial;
    logic                                   c_miss;
    logic                                   accept;

    itl_entry_decode #(.SET_WORDS(SET_WORDS)) u_decode (
        .set_data  (set_data),
        .tag_map   (tag_map),
        .req_tag   (req_tag),
        .cov_map   (cov_map),
        .start_off (start_off)
    );

    itl_lane_gather #(.SET_WORDS(SET_WORDS)) u_gather (
        .set_data  (set_data),
        .cov_map   (cov_map),
        .start_off (start_off),
        .req_mask  (req_mask),
        .lane_cov  (lane_cov),
        .lane_data (lane_data)
    );

    // Classify the request from requested and covered words.
    always_comb begin
        req_mask  = range_mask(req_lo, req_hi);
        c_hit     = (req_mask != '0) && (lane_cov == req_mask);
        c_miss    = (lane_cov == '0);
        c_partial = !c_hit && !c_miss;
    end

    // Handshake: take a request whenever the output register is free or draining.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_partial <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_mask    <= '0;
            rsp_data    <= '0;
        end else if (accept) begin
            rsp_valid   <= 1'b1;
            rsp_hit     <= c_hit;
            rsp_partial <= c_partial;
            rsp_miss    <= c_miss;
            rsp_mask    <= lane_cov;
            rsp_data    <= lane_data;
        end else if (rsp_ready) begin
            rsp_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/itl_set_lookup_checker.sv
// Module itl_set_lookup_checker
// Protocol and output-consistency properties for itl_set_lookup, bound to it.
module itl_set_lookup_checker
    import itl_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_ready,
    input logic                           rsp_valid,
    input logic                           rsp_ready,
    input logic                           rsp_hit,
    input logic                           rsp_partial,
    input logic                           rsp_miss,
    input logic [REGION_WORDS-1:0]        rsp_mask,
    input logic [REGION_WORDS*WORD_W-1:0] rsp_data
);
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_partial, rsp_miss}));

    a_r8_miss_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_mask == '0));

    a_r6_hit_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_mask != '0));

    a_r12_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || rsp_ready) |-> req_ready);

    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask)
                                       && $stable(rsp_data) && $stable(rsp_hit)));

    a_r13_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    for (genvar l = 0; l < REGION_WORDS; l++) begin : g_lane_chk
        a_r9_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && !rsp_mask[l]) |-> (rsp_data[l*WORD_W +: WORD_W] == '0));
    end
endmodule

bind itl_set_lookup itl_set_lookup_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_hit     (rsp_hit),
    .rsp_partial (rsp_partial),
    .rsp_miss    (rsp_miss),
    .rsp_mask    (rsp_mask),
    .rsp_data    (rsp_data)
);

// File: tb/test_itl_set_lookup.sv
// Directed bench for itl_set_lookup: one task per scenario.
module test_itl_set_lookup;
    localparam int NW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW*64-1:0] set_data;
    logic [NW-1:0] tag_map = '0;
    logic [56:0]   req_tag = '0;
    logic [2:0]    req_lo = '0;
    logic [2:0]    req_hi = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic          rsp_hit, rsp_partial, rsp_miss;
    logic [7:0]    rsp_mask;
    logic [511:0]  rsp_data;

    logic [63:0]   sw [NW];
    int            n_chk = 0;
    int            n_bad = 0;
    int            exp_idx [8];

    localparam logic [56:0] TA = 57'h0_ABCD_1234;
    localparam logic [56:0] TB = 57'h1_5555_0F0F;

    always #4 clk = ~clk;

    // Pack the bench's set image onto the port.
    always_comb begin
        for (int i = 0; i < NW; i++) set_data[i*64 +: 64] = sw[i];
    end

    itl_set_lookup i_itl_set_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .set_data(set_data), .tag_map(tag_map), .req_tag(req_tag),
        .req_lo(req_lo), .req_hi(req_hi), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_partial(rsp_partial),
        .rsp_miss(rsp_miss), .rsp_mask(rsp_mask), .rsp_data(rsp_data)
    );

    function automatic logic [63:0] pat(input int i);
        return 64'hD000_0000_0000_0000 | 64'(i);
    endfunction

    function automatic logic [63:0] mk_tag(input logic [56:0] t, input logic [2:0] s,
                                           input logic [2:0] e, input logic v);
        return {t, v, e, s};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic clear_set();
        for (int i = 0; i < NW; i++) sw[i] = pat(i);
        tag_map = '0;
    endtask

    task automatic put_blk(input int p, input logic [56:0] t, input logic [2:0] s,
                           input logic [2:0] e, input logic v, input logic mark);
        sw[p] = mk_tag(t, s, e, v);
        tag_map[p] = mark;
    endtask

    // One request: drive on falling edge, taken on the rising edge, sampled after.
    task automatic issue(input logic [56:0] t, input logic [2:0] lo, input logic [2:0] hi);
        @(negedge clk);
        req_tag = t; req_lo = lo; req_hi = hi; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Compare outcome, mask and all eight lanes; exp_idx[l] < 0 means a zero lane.
    task automatic check_rsp(input string rq, input int outc, input logic [7:0] m);
        chk(rsp_valid === 1'b1, {rq, " valid"}, 64'(rsp_valid), 64'd1);
        chk({rsp_hit, rsp_partial, rsp_miss} ===
            (outc == 0 ? 3'b100 : outc == 1 ? 3'b010 : 3'b001),
            {rq, " outcome"}, 64'({rsp_hit, rsp_partial, rsp_miss}),
            64'(outc == 0 ? 3'b100 : outc == 1 ? 3'b010 : 3'b001));
        chk(rsp_mask === m, {rq, " mask"}, 64'(rsp_mask), 64'(m));
        for (int l = 0; l < 8; l++) begin
            logic [63:0] e;
            e = (exp_idx[l] < 0) ? 64'd0 : pat(exp_idx[l]);
            chk(rsp_data[l*64 +: 64] === e, $sformatf("%s lane%0d", rq, l),
                rsp_data[l*64 +: 64], e);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R13 reset valid", 64'(rsp_valid), 64'd0);
        chk(req_ready === 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);
    endtask

    task automatic t_single_full();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b1, 1'b1);
        issue(TA, 3'd0, 3'd7);
        for (int l = 0; l < 8; l++) exp_idx[l] = 1 + l;
        check_rsp("R6 R3 full block", 0, 8'hFF);
    endtask

    task automatic t_inner();
        clear_set();
        put_blk(10, TA, 3'd2, 3'd5, 1'b1, 1'b1);
        issue(TA, 3'd3, 3'd4);
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        exp_idx[3] = 12; exp_idx[4] = 13;
        check_rsp("R3 R9 inner range", 0, 8'h18);
    endtask

    task automatic t_merge();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd3, 1'b1, 1'b1);
        put_blk(20, TA, 3'd4, 3'd7, 1'b1, 1'b1);
        issue(TA, 3'd0, 3'd7);
        for (int l = 0; l < 4; l++) exp_idx[l] = 1 + l;
        for (int l = 4; l < 8; l++) exp_idx[l] = 21 + (l - 4);
        check_rsp("R6 two-block merge", 0, 8'hFF);
    endtask

    task automatic t_partial();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd3, 1'b1, 1'b1);
        issue(TA, 3'd2, 3'd6);
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        exp_idx[2] = 3; exp_idx[3] = 4;
        check_rsp("R7 partial miss", 1, 8'h0C);
    endtask

    task automatic t_tag_miss();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b1, 1'b1);
        issue(TB, 3'd0, 3'd7);
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        check_rsp("R5 R8 tag mismatch", 2, 8'h00);
    endtask

    task automatic t_ignored();
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b1, 1'b0);
        issue(TA, 3'd0, 3'd7);
        check_rsp("R1 unmarked word", 2, 8'h00);
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b0, 1'b1);
        issue(TA, 3'd0, 3'd7);
        check_rsp("R2 invalid entry", 2, 8'h00);
        clear_set();
        put_blk(0, TA, 3'd5, 3'd2, 1'b1, 1'b1);
        issue(TA, 3'd0, 3'd7);
        check_rsp("R2 reversed entry", 2, 8'h00);
        clear_set();
        put_blk(28, TA, 3'd0, 3'd3, 1'b1, 1'b1);
        put_blk(29, TA, 3'd4, 3'd5, 1'b1, 1'b1);
        issue(TA, 3'd0, 3'd5);
        exp_idx[4] = 30; exp_idx[5] = 31;
        check_rsp("R4 overrun entry", 1, 8'h30);
    endtask

    task automatic t_overlap();
        clear_set();
        put_blk(12, TA, 3'd2, 3'd5, 1'b1, 1'b1);
        put_blk(4, TA, 3'd0, 3'd3, 1'b1, 1'b1);
        issue(TA, 3'd0, 3'd5);
        exp_idx[0] = 5; exp_idx[1] = 6; exp_idx[2] = 7; exp_idx[3] = 8;
        exp_idx[4] = 15; exp_idx[5] = 16; exp_idx[6] = -1; exp_idx[7] = -1;
        check_rsp("R10 overlap priority", 0, 8'h3F);
    endtask

    task automatic t_empty();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b1, 1'b1);
        issue(TA, 3'd5, 3'd2);
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        check_rsp("R8 empty range", 2, 8'h00);
    endtask

    task automatic t_stall();
        clear_set();
        put_blk(0, TA, 3'd0, 3'd7, 1'b1, 1'b1);
        @(negedge clk);
        rsp_ready = 1'b0;
        issue(TA, 3'd1, 3'd1);
        chk(req_ready === 1'b0, "R12 not ready when stalled", 64'(req_ready), 64'd0);
        req_tag = TA; req_lo = 3'd6; req_hi = 3'd6; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < 8; l++) exp_idx[l] = -1;
        exp_idx[1] = 2;
        check_rsp("R12 held while stalled", 0, 8'h02);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp_idx[1] = -1; exp_idx[6] = 7;
        check_rsp("R12 next after drain", 0, 8'h40);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R12 drained", 64'(rsp_valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_set();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_full();
        t_inner();
        t_merge();
        t_partial();
        t_tag_miss();
        t_ignored();
        t_overlap();
        t_empty();
        t_stall();
        finish_run();
    end
endmodule